// File: doc/BRIEF.md
# Memory-Mapped Flash Read Buffer

This block sits between a bus master that reads flash through a memory window and the flash sequencer that runs the serial transfers. Each read address is first matched against four programmable top-of-region addresses. A request whose address lies inside the word window currently held in the buffer is answered from the buffer. If the address is outside that window, the block drops the whole buffer, opens a new window aligned to the buffer size, and asks the sequencer to fetch it. The fetch names the sequence slot that configuration selects.

Words come back from the sequencer in address order. A request is answered as soon as the word it needs has landed. A fetch is never interrupted: a miss that arrives while one is still streaming waits until the last word has landed. Pulsing both soft-reset lines together empties the buffer. A single busy output reports that a mapped access or a fill is in progress.

Top module: `flbuf_top`

## Requirements
- R1: A read belongs to the lowest-numbered region whose top address is strictly greater than the address. Region 0 starts at 0 and region i starts at the top of region i-1. A read at or above every top is answered with `rsp_err`=1, `rsp_data`=0, and no fill is started.
- R2: On a miss the fill starts at the word address aligned down to the window size. `fill_addr` is that byte address minus the start of the request's region. `fill_seq` equals `cfg_fill_seq` as sampled when the fill is launched.
- R3: `cfg_buf_units` counts 8-byte words. The window length is the largest power of two that does not exceed the field, capped at MAX_UNITS, and a value of 0 is taken as 1 word. `fill_units` carries this length. For example 5 gives 4, 3 gives 2 and 200 gives 16.
- R4: A read inside the valid buffered window is answered with the buffered word and starts no fill. Every miss starts exactly one fill.
- R5: A response waits until the requested word has been received. It may be issued while later words of the same fill are still arriving. `rsp_data` is the word the sequencer delivered for that address.
- R6: `fill_start` is never raised while beats of an earlier fill are outstanding. A miss during a fill is held until that fill completes.
- R7: Raising `soft_rst_flash` and `soft_rst_bus` in the same cycle invalidates the buffer, so the next read of a previously buffered address misses. Raising only one of them has no effect.
- R8: When `cfg_all_masters` is 0, a request from a master other than `cfg_owner` is answered with `rsp_err`=1 and `rsp_data`=0, and starts no fill. When it is 1, every master is served.
- R9: `access_busy` is 1 while a request is pending or a fill has beats outstanding, and 0 when both are finished.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `fill_start`=0 and `access_busy`=0, and the buffer is empty.
- R11: One request is outstanding at a time. `req_ready` drops in the cycle after acceptance and returns in the response cycle, and `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_region_top | input | NREG*AW | Top address of each region, region 0 in the low bits |
| cfg_fill_seq | input | 4 | Sequence slot used by fills |
| cfg_buf_units | input | 8 | Window size in 8-byte words |
| cfg_all_masters | input | 1 | Lets any master use the buffer |
| cfg_owner | input | MID_W | Only master allowed when `cfg_all_masters` is 0 |
| soft_rst_flash | input | 1 | Flash-domain soft reset |
| soft_rst_bus | input | 1 | Bus-domain soft reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Byte address of the read |
| req_master | input | MID_W | Requesting master number |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request refused (no region or not permitted) |
| rsp_data | output | DW | Read word |
| fill_start | output | 1 | Pulse that launches a fill |
| fill_seq | output | 4 | Sequence slot for the fill |
| fill_addr | output | AW | Region-local byte address of the fill |
| fill_units | output | $clog2(MAX_UNITS)+1 | Number of words in the fill |
| fill_beat_valid | input | 1 | Word returned by the sequencer |
| fill_beat_data | input | DW | Returned word, in address order |
| access_busy | output | 1 | Mapped access or fill in progress |

## Verification
The hardest case to reach from the ports is a miss that arrives while an earlier fill is still streaming. To get there, the bench's sequencer model returns words at a low random rate. The bench then reads the first word of a fresh 16-word window, which is answered after a single beat, and at once issues a read to a different window. The sequencer model flags any launch it sees while it still owes beats, and the bench confirms that the second read is served by exactly one later fill. A second directed case reads the last word of a window to show the response waiting for the final beat. Soft-reset pulses are mixed into the random stream, both lines together and one line alone.

// File: rtl/flbuf_pkg.sv
package flbuf_pkg;

    // Bytes per buffered word and its log.
    localparam int UNIT_BYTES = 8;
    localparam int UNIT_SHIFT = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOOK = 1'b1
    } req_state_e;

    // Outcome of one lookup cycle.
    typedef struct packed {
        logic respond;
        logic refuse;
        logic launch;
    } look_act_t;

    // Log2 of the window length: highest set bit of the size field,
    // capped at max_log; a zero field gives 0 (one word).
    function automatic logic [3:0] units_log(input logic [7:0] field,
                                             input int unsigned max_log);
        logic [3:0] k;
        k = 4'd0;
        for (int i = 0; i < 8; i++) begin
            if (field[i]) k = 4'(i);
        end
        if (32'(k) > max_log) k = 4'(max_log);
        return k;
    endfunction

endpackage

// File: rtl/flbuf_region_dec.sv
module flbuf_region_dec #(
    parameter int AW   = 32,
    parameter int NREG = 4
) (
    input  logic [AW-1:0]      addr,
    input  logic [NREG*AW-1:0] tops,
    output logic               found,
    output logic [AW-1:0]      start
);

    logic [NREG-1:0] below;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cmp
            assign below[g] = addr < tops[g*AW +: AW];
        end
    endgenerate

    // Lowest region whose top lies above the address wins.
    always_comb begin
        logic [AW-1:0] prev;
        prev  = '0;
        found = 1'b0;
        start = '0;
        for (int i = 0; i < NREG; i++) begin
            if (!found && below[i]) begin
                found = 1'b1;
                start = prev;
            end
            prev = tops[i*AW +: AW];
        end
    end

endmodule

// File: rtl/flbuf_store.sv
module flbuf_store #(
    parameter int WAW       = 29,
    parameter int DW        = 64,
    parameter int MAX_UNITS = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           inv,
    input  logic           open,
    input  logic [WAW-1:0] open_base,
    input  logic [3:0]     open_log,
    input  logic           beat_valid,
    input  logic [DW-1:0]  beat_data,
    input  logic [WAW-1:0] look_word,
    output logic           hit,
    output logic           filled,
    output logic [DW-1:0]  rd_data,
    output logic           fill_active
);

    localparam int MAX_LOG = $clog2(MAX_UNITS);
    localparam int OW      = (MAX_LOG > 0) ? MAX_LOG : 1;
    localparam int CW      = MAX_LOG + 1;

    logic [DW-1:0]  mem [MAX_UNITS];
    logic           buf_valid;
    logic [WAW-1:0] base_word;
    logic [3:0]     win_log;
    logic [CW-1:0]  beat_cnt;
    logic [CW-1:0]  beat_next;
    logic [CW-1:0]  total;
    logic [OW-1:0]  offset;

    assign total     = CW'(1) << win_log;
    assign beat_next = beat_cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_valid   <= 1'b0;
            base_word   <= '0;
            win_log     <= '0;
            beat_cnt    <= '0;
            fill_active <= 1'b0;
        end else begin
            if (open) begin
                buf_valid   <= 1'b1;
                base_word   <= open_base;
                win_log     <= open_log;
                beat_cnt    <= '0;
                fill_active <= 1'b1;
            end else if (fill_active && beat_valid) begin
                beat_cnt <= beat_next;
                if (beat_next == total) fill_active <= 1'b0;
            end
            // Invalidation wins; a running fill still drains its beats.
            if (inv) buf_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_active && beat_valid) mem[beat_cnt[OW-1:0]] <= beat_data;
    end

    assign hit     = buf_valid && (((look_word ^ base_word) >> win_log) == '0);
    assign offset  = look_word[OW-1:0] - base_word[OW-1:0];
    assign filled  = !fill_active || ({1'b0, offset} < beat_cnt);
    assign rd_data = mem[offset];

endmodule

// File: rtl/flbuf_top.sv
module flbuf_top
    import flbuf_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int NREG      = 4,
    parameter int MAX_UNITS = 16,
    parameter int MID_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREG*AW-1:0]          cfg_region_top,
    input  logic [3:0]                  cfg_fill_seq,
    input  logic [7:0]                  cfg_buf_units,
    input  logic                        cfg_all_masters,
    input  logic [MID_W-1:0]            cfg_owner,
    input  logic                        soft_rst_flash,
    input  logic                        soft_rst_bus,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [AW-1:0]               req_addr,
    input  logic [MID_W-1:0]            req_master,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [DW-1:0]               rsp_data,
    output logic                        fill_start,
    output logic [3:0]                  fill_seq,
    output logic [AW-1:0]               fill_addr,
    output logic [$clog2(MAX_UNITS):0]  fill_units,
    input  logic                        fill_beat_valid,
    input  logic [DW-1:0]               fill_beat_data,
    output logic                        access_busy
);

    localparam int MAX_LOG = $clog2(MAX_UNITS);
    localparam int CW      = MAX_LOG + 1;
    localparam int WAW     = AW - UNIT_SHIFT;

    req_state_e       state;
    logic [AW-1:0]    q_addr;
    logic [MID_W-1:0] q_master;

    logic             reg_found;
    logic [AW-1:0]    reg_start;
    logic             buf_hit;
    logic             buf_filled;
    logic [DW-1:0]    buf_data;
    logic             fill_busy;
    logic             master_ok;
    logic [3:0]       eff_log;
    logic [WAW-1:0]   look_word;
    logic [WAW-1:0]   win_mask;
    logic [WAW-1:0]   open_base;
    look_act_t        act;

    flbuf_region_dec #(
        .AW   (AW),
        .NREG (NREG)
    ) u_dec (
        .addr  (q_addr),
        .tops  (cfg_region_top),
        .found (reg_found),
        .start (reg_start)
    );

    assign look_word = q_addr[AW-1:UNIT_SHIFT];
    assign eff_log   = units_log(cfg_buf_units, MAX_LOG);
    assign win_mask  = ~((WAW'(1) << eff_log) - WAW'(1));
    assign open_base = look_word & win_mask;
    assign master_ok = cfg_all_masters || (q_master == cfg_owner);

    flbuf_store #(
        .WAW       (WAW),
        .DW        (DW),
        .MAX_UNITS (MAX_UNITS)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .inv         (soft_rst_flash && soft_rst_bus),
        .open        (act.launch),
        .open_base   (open_base),
        .open_log    (eff_log),
        .beat_valid  (fill_beat_valid),
        .beat_data   (fill_beat_data),
        .look_word   (look_word),
        .hit         (buf_hit),
        .filled      (buf_filled),
        .rd_data     (buf_data),
        .fill_active (fill_busy)
    );

    // One decision per lookup cycle: refuse, answer, wait, or launch.
    always_comb begin
        act = '0;
        if (state == ST_LOOK) begin
            if (!reg_found || !master_ok) begin
                act.respond = 1'b1;
                act.refuse  = 1'b1;
            end else if (buf_hit) begin
                act.respond = buf_filled;
            end else begin
                act.launch = !fill_busy;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            q_addr     <= '0;
            q_master   <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_data   <= '0;
            fill_start <= 1'b0;
            fill_seq   <= '0;
            fill_addr  <= '0;
            fill_units <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            fill_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_addr   <= req_addr;
                        q_master <= req_master;
                        state    <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (act.respond) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_err   <= act.refuse;
                        rsp_data  <= act.refuse ? '0 : buf_data;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (act.launch) begin
                fill_start <= 1'b1;
                fill_seq   <= cfg_fill_seq;
                fill_addr  <= {open_base, {UNIT_SHIFT{1'b0}}} - reg_start;
                fill_units <= CW'(1) << eff_log;
            end
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign access_busy = (state == ST_LOOK) || fill_busy;

endmodule

// File: rtl/flbuf_chk.sv
module flbuf_chk #(
    parameter int MAX_UNITS = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       rsp_valid,
    input logic                       fill_start,
    input logic [3:0]                 fill_seq,
    input logic [$clog2(MAX_UNITS):0] fill_units,
    input logic                       fill_beat_valid,
    input logic [3:0]                 cfg_fill_seq,
    input logic                       access_busy
);

    localparam int CW = $clog2(MAX_UNITS) + 1;

    // Beats still owed by the sequencer, tracked from the ports.
    logic [CW-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (fill_start) begin
            pend <= fill_units - CW'(fill_beat_valid);
        end else if (fill_beat_valid && pend != '0) begin
            pend <= pend - CW'(1);
        end
    end

    assert_launch_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
        fill_start |-> (pend == '0));

    assert_busy_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> access_busy);

    assert_busy_pending_R9: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> access_busy);

    assert_fill_seq_R2: assert property (@(posedge clk) disable iff (rst)
        fill_start |-> (fill_seq == $past(cfg_fill_seq)));

    assert_fill_pow2_R3: assert property (@(posedge clk) disable iff (rst)
        fill_start |-> ($countones(fill_units) == 1));

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind flbuf_top flbuf_chk #(
    .MAX_UNITS (MAX_UNITS)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .rsp_valid       (rsp_valid),
    .fill_start      (fill_start),
    .fill_seq        (fill_seq),
    .fill_units      (fill_units),
    .fill_beat_valid (fill_beat_valid),
    .cfg_fill_seq    (cfg_fill_seq),
    .access_busy     (access_busy)
);

// File: tb/tb_flbuf_top.sv
`timescale 1ns/1ps
module tb_flbuf_top;

    localparam int AW        = 32;
    localparam int DW        = 64;
    localparam int NREG      = 4;
    localparam int MAX_UNITS = 16;
    localparam int MID_W     = 4;
    localparam int CW        = $clog2(MAX_UNITS) + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NREG*AW-1:0]   cfg_region_top;
    logic [3:0]           cfg_fill_seq = 4'd0;
    logic [7:0]           cfg_buf_units = 8'd4;
    logic                 cfg_all_masters = 1'b1;
    logic [MID_W-1:0]     cfg_owner = 4'd3;
    logic                 soft_rst_flash = 1'b0;
    logic                 soft_rst_bus = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [AW-1:0]        req_addr = '0;
    logic [MID_W-1:0]     req_master = '0;
    logic                 rsp_valid;
    logic                 rsp_err;
    logic [DW-1:0]        rsp_data;
    logic                 fill_start;
    logic [3:0]           fill_seq;
    logic [AW-1:0]        fill_addr;
    logic [CW-1:0]        fill_units;
    logic                 fill_beat_valid;
    logic [DW-1:0]        fill_beat_data;
    logic                 access_busy;

    always #2 clk = ~clk;

    flbuf_top #(
        .AW(AW), .DW(DW), .NREG(NREG), .MAX_UNITS(MAX_UNITS), .MID_W(MID_W)
    ) dut (
        .clk(clk), .rst(rst), .cfg_region_top(cfg_region_top),
        .cfg_fill_seq(cfg_fill_seq), .cfg_buf_units(cfg_buf_units),
        .cfg_all_masters(cfg_all_masters), .cfg_owner(cfg_owner),
        .soft_rst_flash(soft_rst_flash), .soft_rst_bus(soft_rst_bus),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_master(req_master), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .fill_start(fill_start), .fill_seq(fill_seq),
        .fill_addr(fill_addr), .fill_units(fill_units),
        .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
        .access_busy(access_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    localparam logic [31:0] TOP0 = 32'h1000;
    localparam logic [31:0] TOP1 = 32'h2000;
    localparam logic [31:0] TOP2 = 32'h3000;
    localparam logic [31:0] TOP3 = 32'h4000;

    function automatic int region_of(input logic [31:0] a);
        if (a < TOP0) return 0;
        if (a < TOP1) return 1;
        if (a < TOP2) return 2;
        if (a < TOP3) return 3;
        return -1;
    endfunction

    function automatic logic [31:0] start_of(input int r);
        case (r)
            1: return TOP0;
            2: return TOP1;
            3: return TOP2;
            default: return 32'h0;
        endcase
    endfunction

    function automatic int eff_units(input logic [7:0] f);
        int u;
        if (f == 8'd0) return 1;
        u = 1;
        while (u * 2 <= int'(f) && u * 2 <= MAX_UNITS) u = u * 2;
        return u;
    endfunction

    function automatic logic [63:0] pat(input logic [31:0] la);
        return {la ^ 32'hC0DE_0000, la + 32'h0000_0011};
    endfunction

    // Sequencer model state.
    int          seq_left = 0;
    int          seq_idx  = 0;
    int          n_fills  = 0;
    int          beat_pct = 100;
    logic [31:0] rec_addr = '0;
    int          rec_units = 0;
    logic [3:0]  rec_seq = '0;

    // Buffer model state.
    bit          m_valid = 1'b0;
    int          m_base  = 0;
    int          m_units = 0;
    logic [31:0] m_start = '0;
    int          last_left = 0;

    initial begin
        fill_beat_valid = 1'b0;
        fill_beat_data  = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                seq_left = 0;
                fill_beat_valid = 1'b0;
            end else begin
                if (fill_start) begin
                    chk(seq_left == 0, "R6 no launch with beats owed", 64'(seq_left), 64'd0);
                    rec_addr  = fill_addr;
                    rec_units = int'(fill_units);
                    rec_seq   = fill_seq;
                    seq_left  = int'(fill_units);
                    seq_idx   = 0;
                    n_fills++;
                end
                if (seq_left > 0 && int'($urandom_range(99)) < beat_pct) begin
                    fill_beat_valid = 1'b1;
                    fill_beat_data  = pat(rec_addr + 32'(seq_idx * 8));
                    seq_idx++;
                    seq_left--;
                end else begin
                    fill_beat_valid = 1'b0;
                end
            end
        end
    end

    task automatic do_read(input logic [31:0] a, input logic [3:0] m);
        int r;
        int w;
        int eff;
        int f0;
        int waitc;
        bit err;
        bit miss;
        logic [31:0] wa;
        logic [31:0] st;
        logic [31:0] exp_fa;
        logic [63:0] exp_d;
        wa     = {a[31:3], 3'b000};
        r      = region_of(wa);
        err    = (r < 0) || (!cfg_all_masters && (m != cfg_owner));
        w      = int'(wa >> 3);
        miss   = 1'b0;
        eff    = 0;
        exp_fa = '0;
        exp_d  = '0;
        if (!err) begin
            st = start_of(r);
            if (!(m_valid && w >= m_base && w < m_base + m_units)) begin
                miss    = 1'b1;
                eff     = eff_units(cfg_buf_units);
                m_valid = 1'b1;
                m_base  = w - (w % eff);
                m_units = eff;
                m_start = st;
                exp_fa  = 32'(m_base * 8) - st;
            end
            exp_d = pat(wa - m_start);
        end
        f0 = n_fills;
        @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_master = m;
        waitc = 0;
        while (!req_ready && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low while pending", 64'(req_ready), 64'd0);
        chk(access_busy == 1'b1, "R9 busy while pending", 64'(access_busy), 64'd1);
        waitc = 0;
        while (!rsp_valid && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        last_left = seq_left;
        chk(rsp_valid == 1'b1, "R5 response delivered", 64'(rsp_valid), 64'd1);
        chk(rsp_err == err, "R1,R8 error flag", 64'(rsp_err), 64'(err));
        if (!err) chk(rsp_data == exp_d, "R4,R5 read data", rsp_data, exp_d);
        else      chk(rsp_data == '0, "R1,R8 zero data on error", rsp_data, 64'd0);
        chk((n_fills - f0) == (miss ? 1 : 0), "R4 one fill per miss only",
            64'(n_fills - f0), 64'(miss));
        if (miss) begin
            chk(rec_addr == exp_fa, "R2 fill address", 64'(rec_addr), 64'(exp_fa));
            chk(rec_units == eff, "R3 fill length", 64'(rec_units), 64'(eff));
            chk(rec_seq == cfg_fill_seq, "R2 fill sequence", 64'(rec_seq), 64'(cfg_fill_seq));
        end
        chk(req_ready == 1'b1, "R11 ready in response cycle", 64'(req_ready), 64'd1);
    endtask

    task automatic wait_drain();
        while (seq_left > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(access_busy == 1'b0, "R9 idle when drained", 64'(access_busy), 64'd0);
    endtask

    task automatic soft_pulse(input bit fl, input bit bu);
        @(negedge clk);
        soft_rst_flash = fl;
        soft_rst_bus   = bu;
        @(negedge clk);
        soft_rst_flash = 1'b0;
        soft_rst_bus   = 1'b0;
        if (fl && bu) m_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] last_a;
        void'($urandom(32'd7321));
        cfg_region_top = {TOP3, TOP2, TOP1, TOP0};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 64'd0);
        chk(fill_start == 1'b0, "R10 no fill after reset", 64'(fill_start), 64'd0);
        chk(access_busy == 1'b0, "R10 not busy after reset", 64'(access_busy), 64'd0);

        // R1 region boundaries and out-of-range
        cfg_fill_seq = 4'd2;
        cfg_buf_units = 8'd4;
        do_read(32'h0000_0FF8, 4'd0);
        do_read(32'h0000_1000, 4'd0);
        do_read(32'h0000_1008, 4'd0);
        do_read(32'h0000_4000, 4'd0);
        do_read(32'hFFFF_FFF8, 4'd0);
        do_read(32'h0000_3FF8, 4'd0);

        // R3 size field rounding, zero and clamp
        cfg_buf_units = 8'd0;   do_read(32'h0000_2200, 4'd1);
        cfg_buf_units = 8'd5;   do_read(32'h0000_2410, 4'd1);
        cfg_buf_units = 8'd3;   do_read(32'h0000_0508, 4'd1);
        cfg_buf_units = 8'd200; do_read(32'h0000_0A48, 4'd1);
        do_read(32'h0000_0A00, 4'd1);
        wait_drain();

        // R8 master permission
        cfg_all_masters = 1'b0;
        cfg_owner = 4'd3;
        do_read(32'h0000_0A10, 4'd5);
        do_read(32'h0000_1800, 4'd5);
        do_read(32'h0000_0A18, 4'd3);
        cfg_all_masters = 1'b1;
        do_read(32'h0000_0A20, 4'd5);

        // R7 soft reset: one line alone keeps the buffer, both clear it
        soft_pulse(1'b0, 1'b1);
        do_read(32'h0000_0A28, 4'd2);
        soft_pulse(1'b1, 1'b0);
        do_read(32'h0000_0A30, 4'd2);
        soft_pulse(1'b1, 1'b1);
        do_read(32'h0000_0A30, 4'd2);
        wait_drain();

        // R5 early word served mid-fill, then R6 miss during that fill
        cfg_buf_units = 8'd16;
        beat_pct = 12;
        do_read(32'h0000_2000, 4'd1);
        chk(last_left > 0, "R5 answered before fill end", 64'(last_left), 64'd1);
        chk(seq_left > 0, "R6 fill still running at next miss", 64'(seq_left), 64'd1);
        do_read(32'h0000_0100, 4'd1);
        wait_drain();

        // R5 last word of a window waits for the final beat
        beat_pct = 40;
        do_read(32'h0000_3078, 4'd1);
        chk(last_left == 0, "R5 last word waits for final beat", 64'(last_left), 64'd0);
        wait_drain();

        // Random mix
        last_a = 32'h0000_0800;
        for (int i = 0; i < 220; i++) begin
            logic [31:0] a;
            if (i % 20 == 0) begin
                case ($urandom_range(8))
                    0: cfg_buf_units = 8'd0;
                    1: cfg_buf_units = 8'd1;
                    2: cfg_buf_units = 8'd2;
                    3: cfg_buf_units = 8'd3;
                    4: cfg_buf_units = 8'd4;
                    5: cfg_buf_units = 8'd7;
                    6: cfg_buf_units = 8'd8;
                    7: cfg_buf_units = 8'd16;
                    default: cfg_buf_units = 8'd100;
                endcase
            end
            cfg_fill_seq    = 4'($urandom_range(15));
            cfg_all_masters = ($urandom_range(9) < 7);
            beat_pct        = 30 + int'($urandom_range(70));
            if ($urandom_range(1) == 0)
                a = last_a + 32'($urandom_range(128)) - 32'd64;
            else
                a = 32'($urandom_range(32'h47FF));
            a = a & 32'hFFFF_FFF8;
            if ($urandom_range(19) == 0) soft_pulse($urandom_range(1) == 1, $urandom_range(1) == 1);
            do_read(a, 4'($urandom_range(7)));
            last_a = a;
        end
        wait_drain();

        summary();
        $finish;
    end

endmodule